// File: doc/BRIEF.md
# Software-Driven Two-Wire Line Register

This peripheral lets software drive the clock and data wires of a two-wire serial bus directly, one bit at a time. A small synchronous bus slave exposes one status/raise location and one lower location inside a 4 KB window. Software raises line bits by writing ones to the raise offset and lowers them by writing ones to the lower offset. A single read returns the clock bit currently being driven and the data wire as seen from outside.

Both wires are driven open-drain. A state bit of 0 turns on a pull-low driver. A state bit of 1 releases the wire, and an external pull-up then sets its level. The data wire passes through a two-flop synchronizer before it can be read. The block has no byte engine, no clock stretching and no interrupts. Software sequences start, data, acknowledge and stop conditions itself.

Top module: `twb_line_reg`

## Requirements
- R1: After reset the line state is 2'b11. Both pull-low enables (`scl_pull`, `sda_pull`) are 0, and a read at offset 0x0 returns 0x3 while `sda_in` is high.
- R2: A write at offset 0x0 ORs write-data bits [1:0] into the line state (bit 0 = clock, bit 1 = data). Write-data bits above bit 1 have no effect.
- R3: A write at offset 0x4 clears every line-state bit whose matching write-data bit in [1:0] is 1, and leaves the other bit unchanged.
- R4: A read at offset 0x0 returns the driven clock state bit in bit 0 and the synchronized data-wire level in bit 1. All other bits read 0.
- R5: A read at any offset other than 0x0, or a write at any offset other than 0x0 or 0x4, raises `bus_err` in the same cycle, returns read data 0 and leaves the line state unchanged.
- R6: Decode uses only the low 12 address bits. Address bits above bit 11 are ignored.
- R7: `scl_pull` equals the inverse of line-state bit 0, and `sda_pull` equals the inverse of line-state bit 1.
- R8: A change on `sda_in` appears in read bit 1 after exactly two rising clock edges.
- R9: Read data and `bus_err` are valid in the cycle of the access. A write changes the line state, and so the pull-low outputs, at the next rising edge.
- R10: While `bus_sel` is low, `bus_err` is 0, read data is 0 and the line state does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; only the low 12 bits are decoded |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| bus_err | output | 1 | Bad-offset error response, combinational |
| scl_pull | output | 1 | Enable of the clock-wire pull-low driver |
| sda_pull | output | 1 | Enable of the data-wire pull-low driver |
| sda_in | input | 1 | Level sensed on the data wire |

## Verification
On every cycle, the assertions check the following. A raise write leaves every written bit set. A lower write leaves every written bit clear. A rejected access leaves the line state untouched. An idle bus holds the pull-low outputs. A read returns zeros above bit 1, with bit 0 matching the clock drive. The synchronizer output equals the input from two edges earlier. Only the bench scenarios can show the following: the full raise and lower sweep over every start state and mask, the same-cycle timing of error and read data, aliasing through the upper address bits, and the exact edge at which a data-wire change becomes visible.

// File: rtl/twb_pkg.sv
package twb_pkg;
  localparam int unsigned TWB_WIN_BITS = 12;
  localparam logic [TWB_WIN_BITS-1:0] TWB_OFS_RAISE = 12'h000;
  localparam logic [TWB_WIN_BITS-1:0] TWB_OFS_LOWER = 12'h004;
  localparam int unsigned TWB_LINES = 2;

  typedef enum logic [2:0] {
    ACC_IDLE,
    ACC_RAISE,
    ACC_LOWER,
    ACC_READ,
    ACC_BAD
  } twb_acc_e;
endpackage

// File: rtl/twb_decode.sv
module twb_decode
  import twb_pkg::*;
(
  input  logic                    sel_i,
  input  logic                    wr_i,
  input  logic [TWB_WIN_BITS-1:0] ofs_i,
  output twb_acc_e                acc_o
);
  always_comb begin
    acc_o = ACC_IDLE;
    if (sel_i) begin
      if (wr_i) begin
        if (ofs_i == TWB_OFS_RAISE)      acc_o = ACC_RAISE;
        else if (ofs_i == TWB_OFS_LOWER) acc_o = ACC_LOWER;
        else                             acc_o = ACC_BAD;
      end else begin
        if (ofs_i == TWB_OFS_RAISE)      acc_o = ACC_READ;
        else                             acc_o = ACC_BAD;
      end
    end
  end
endmodule

// File: rtl/twb_lines.sv
module twb_lines
  import twb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 raise_en_i,
  input  logic                 lower_en_i,
  input  logic [TWB_LINES-1:0] mask_i,
  output logic [TWB_LINES-1:0] state_o
);
  logic [TWB_LINES-1:0] state_q, state_d;
  logic                 upd_en;

  assign upd_en = raise_en_i | lower_en_i;

  always_comb begin
    state_d = state_q;
    if (raise_en_i)      state_d = state_q | mask_i;
    else if (lower_en_i) state_d = state_q & ~mask_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= '1;
    else if (upd_en) state_q <= state_d;
  end

  assign state_o = state_q;

  // R2
  raise_sets_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raise_en_i |=> ((state_q & $past(mask_i)) == $past(mask_i)));
  // R3
  lower_clears_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lower_en_i |=> ((state_q & $past(mask_i)) == '0));
endmodule

// File: rtl/twb_sync.sv
module twb_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      logic [1:0] age_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           age_q <= '0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
      end
      // R8
      sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (q_o == $past(d_i, 2)));
    end
  endgenerate
endmodule

// File: rtl/twb_line_reg.sv
module twb_line_reg
  import twb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic              scl_pull,
  output logic              sda_pull,
  input  logic              sda_in
);
  localparam int unsigned PAD_W = DATA_W - TWB_LINES;

  logic [1:0]           rst_pipe_q;
  logic                 rst_int_n;
  twb_acc_e             acc;
  logic [TWB_LINES-1:0] line_state;
  logic                 sda_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  twb_decode u_decode (
    .sel_i (bus_sel),
    .wr_i  (bus_wr),
    .ofs_i (bus_addr[TWB_WIN_BITS-1:0]),
    .acc_o (acc)
  );

  twb_lines u_lines (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .raise_en_i (acc == ACC_RAISE),
    .lower_en_i (acc == ACC_LOWER),
    .mask_i     (bus_wdata[TWB_LINES-1:0]),
    .state_o    (line_state)
  );

  twb_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sda_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (sda_in),
    .q_o   (sda_seen)
  );

  always_comb begin
    bus_rdata = '0;
    if (acc == ACC_READ) bus_rdata = {{PAD_W{1'b0}}, sda_seen, line_state[0]};
  end

  assign bus_err  = (acc == ACC_BAD);
  assign scl_pull = ~line_state[0];
  assign sda_pull = ~line_state[1];

  // R5
  bad_access_no_change_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    bus_err |=> $stable({scl_pull, sda_pull}));
  // R4
  read_format_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_sel && !bus_wr && !bus_err) |->
      (bus_rdata[DATA_W-1:2] == '0 && bus_rdata[0] == ~scl_pull));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_sel |=> $stable({scl_pull, sda_pull}));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_sel |-> (!bus_err && bus_rdata == '0));
endmodule

// File: tb/twb_line_reg_bench.sv
module twb_line_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr, sda_in;
  logic [31:0] bus_addr, bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_err, scl_pull, sda_pull;
  int checks = 0;
  int failures = 0;
  logic [1:0] model;

  always #5 clk = ~clk;

  twb_line_reg u_twb_line_reg (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .scl_pull(scl_pull), .sda_pull(sda_pull), .sda_in(sda_in)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R7: pull enables are the inverse of the modelled state
  task automatic chk_lines(input string req);
    chk(req, {30'd0, sda_pull, scl_pull}, {30'd0, ~model});
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic exp_err);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    #1 chk("R5/R9 write err", {31'd0, bus_err}, {31'd0, exp_err});
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [31:0] a, input logic exp_err,
                    input logic [31:0] exp_data);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 chk({req, " err"}, {31'd0, bus_err}, {31'd0, exp_err});
    chk({req, " data"}, bus_rdata, exp_data);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic force_state(input logic [1:0] s);
    wr(32'h4, 32'h3, 1'b0);
    wr(32'h0, {30'd0, s}, 1'b0);
    model = s;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    sda_in = 1'b1; model = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk_lines("R1 reset pulls");
    rd("R1 reset read", 32'h0, 1'b0, 32'h3);
    // R10 idle bus
    #1 chk("R10 idle err", {31'd0, bus_err}, 32'd0);
    chk("R10 idle rdata", bus_rdata, 32'd0);

    // R2/R3 exhaustive sweep over start state and mask, with high-bit noise
    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 4; m++) begin
        force_state(s[1:0]);
        wr(32'h0, 32'hFFFF_FFF0 | m, 1'b0);
        model = s[1:0] | m[1:0];
        chk_lines("R2 raise");
        rd("R4 read after raise", 32'h0, 1'b0, {30'd0, 1'b1, model[0]});
        force_state(s[1:0]);
        wr(32'h4, {30'd0, m[1:0]}, 1'b0);
        model = s[1:0] & ~m[1:0];
        chk_lines("R3 lower");
      end
    end

    // R9 write takes effect at next edge only
    force_state(2'b11);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 32'h4; bus_wdata = 32'h1;
    #1 chk("R9 before edge", {31'd0, scl_pull}, 32'd0);
    @(negedge clk);
    bus_sel = 1'b0;
    chk("R9 after edge", {31'd0, scl_pull}, 32'd1);
    model = 2'b10;

    // R5 bad offsets: no state change
    force_state(2'b01);
    for (int k = 0; k < 6; k++) begin
      logic [31:0] bad;
      case (k)
        0: bad = 32'h1; 1: bad = 32'h2; 2: bad = 32'h3;
        3: bad = 32'h8; 4: bad = 32'hFFC; default: bad = 32'h5;
      endcase
      wr(bad, 32'h3, 1'b1);
      chk_lines("R5 bad write no change");
    end
    rd("R5 read at 0x4", 32'h4, 1'b1, 32'd0);
    rd("R5 read at 0x800", 32'h800, 1'b1, 32'd0);
    chk_lines("R5 bad read no change");

    // R6 aliasing through upper address bits
    force_state(2'b00);
    wr(32'h1234_5000, 32'h2, 1'b0);
    model = 2'b10;
    chk_lines("R6 alias raise");
    wr(32'hABCD_E004, 32'h2, 1'b0);
    model = 2'b00;
    chk_lines("R6 alias lower");
    rd("R6 alias read", 32'hFFFF_F000, 1'b0, 32'h2);
    wr(32'h0000_1008, 32'h3, 1'b1);
    chk_lines("R6 alias bad");

    // R8 synchronizer latency
    @(negedge clk);
    sda_in = 1'b0;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 32'h0;
    @(negedge clk);
    #1 chk("R8 one edge", {31'd0, bus_rdata[1]}, 32'd1);
    @(negedge clk);
    #1 chk("R8 two edges", {31'd0, bus_rdata[1]}, 32'd0);
    bus_sel = 1'b0;
    sda_in = 1'b1;
    repeat (2) @(negedge clk);
    rd("R8 back high", 32'h0, 1'b0, 32'h2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule